// File: doc/BRIEF.md
# Stop Recovery and Low-Voltage Monitor Control

This block keeps a five-bit configuration register. The register controls a digital low-voltage monitor and the wake-up timing of a processor that can enter stop mode. The monitor's comparator result arrives as a digital input. The block decides whether the monitor is powered. It also decides whether a low-voltage condition raises a reset request and which supply range (5 V or 3 V) the monitor is set for.

When the processor enters stop mode, the block drops `cpu_run`. On a wake request it starts a recovery count, and `cpu_run` returns once the count has run out. The count is short or long, chosen by a register bit. A wake-up caused by a low-voltage reset always takes the long count. The supply-range bit survives a general reset and is cleared only by power-on reset.

Top module: `stoprec_ctrl`

## Requirements
- R1: A write with `cfg_wr` high stores `cfg_wdata` on the next rising clock edge. The field positions are: bit 0 selects short recovery, bit 1 keeps the monitor on during stop, bit 2 blocks the reset request, bit 3 powers the monitor off, and bit 4 selects 5-V mode.
- R2: `lvi_enable` is high exactly when the power-off bit is 0 and either the block is not in stop/recovery or the stop-keep bit is 1.
- R3: `lvi_reset` is high exactly when `lvi_detect` is high, `lvi_enable` is high and the reset-block bit is 0.
- R4: `lvi_mode_5v` equals the stored 5-V bit (1 means 5 V, 0 means 3 V).
- R5: A `stop_enter` pulse while running makes `cpu_run` low from the next edge on, and it stays low until a recovery completes.
- R6: With the short-recovery bit at 1, a wake request seen in stop keeps `cpu_run` low for exactly SHORT_DLY (default 32) cycles after the accepting edge.
- R7: With the short-recovery bit at 0, the same wake-up takes LONG_DLY (default 4096) cycles.
- R8: In stop, an asserted `lvi_reset` starts the recovery with the LONG_DLY count, whatever the short-recovery bit holds.
- R9: A register write during a running recovery does not change the length of that recovery.
- R10: A general reset (`rst_n` low) clears every configuration bit except the 5-V bit, which keeps its value, and leaves `cpu_run` high.
- R11: A power-on reset (`por_n` low) clears all configuration bits, including the 5-V bit, and leaves `cpu_run` high.
- R12: `wake_req` has no effect while running or while a recovery is already counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | General reset, active low, synchronous |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 5 | Register write data |
| stop_enter | input | 1 | Processor requests stop mode |
| wake_req | input | 1 | Wake request while in stop |
| lvi_detect | input | 1 | Raw low-voltage detect |
| lvi_enable | output | 1 | Monitor power enable |
| lvi_reset | output | 1 | Low-voltage reset request |
| lvi_mode_5v | output | 1 | Monitor range: 1 = 5 V, 0 = 3 V |
| cpu_run | output | 1 | Processor clocks released |

## Verification
A register write becomes visible one clock edge after the strobe. After that, `lvi_enable`, `lvi_reset` and `lvi_mode_5v` follow with no further delay, because they are combinational from the register, the stop state and the detect input. `cpu_run` falls one edge after `stop_enter`. It rises exactly SHORT_DLY or LONG_DLY edges after the edge that accepted the wake-up. The bench changes inputs and samples outputs only on falling edges. It measures a recovery by counting the falling edges that see `cpu_run` low, starting after the accepting edge, and compares that count with the expected delay.

// File: rtl/stoprec_pkg.sv
package stoprec_pkg;

    localparam int unsigned CFG_W = 5;

    // Field order matches write-data bit order, MSB first (bit 4 .. bit 0)
    typedef struct packed {
        logic mode_5v;
        logic pwr_off;
        logic rst_off;
        logic stop_keep;
        logic short_rec;
    } stoprec_cfg_t;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOP    = 2'd1,
        ST_RECOVER = 2'd2
    } stoprec_state_e;

endpackage

// File: rtl/stoprec_cfg_reg.sv
module stoprec_cfg_reg
    import stoprec_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    output stoprec_cfg_t       cfg_o
);

    stoprec_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = stoprec_cfg_t'(wr_data);
        end
        if (!rst_n) begin
            cfg_d         = '0;
            cfg_d.mode_5v = cfg_q.mode_5v;
        end
        if (!por_n) begin
            cfg_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R10
    mode_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n) |=> (cfg_q.mode_5v == $past(cfg_q.mode_5v)) && (cfg_q[CFG_W-2:0] == '0));

    // R11
    por_clear_chk: assert property (@(posedge clk)
        (!por_n) |=> (cfg_q == '0));

endmodule

// File: rtl/stoprec_lvi_ctrl.sv
module stoprec_lvi_ctrl
    import stoprec_pkg::*;
(
    input  logic         clk,
    input  logic         rst_any,
    input  stoprec_cfg_t cfg,
    input  logic         in_stop,
    input  logic         lvi_detect,
    output logic         lvi_enable,
    output logic         lvi_reset,
    output logic         lvi_mode_5v
);

    logic mon_on;

    always_comb begin
        mon_on      = !cfg.pwr_off && (!in_stop || cfg.stop_keep);
        lvi_enable  = mon_on;
        lvi_reset   = lvi_detect && mon_on && !cfg.rst_off;
        lvi_mode_5v = cfg.mode_5v;
    end

    // R3
    rst_block_chk: assert property (@(posedge clk) disable iff (rst_any)
        cfg.rst_off |-> !lvi_reset);

    // R2
    pwr_off_chk: assert property (@(posedge clk) disable iff (rst_any)
        cfg.pwr_off |-> (!lvi_enable && !lvi_reset));

endmodule

// File: rtl/stoprec_wake_timer.sv
module stoprec_wake_timer
    import stoprec_pkg::*;
#(
    parameter int unsigned SHORT_DLY = 32,
    parameter int unsigned LONG_DLY  = 4096
) (
    input  logic clk,
    input  logic rst_any,
    input  logic stop_enter,
    input  logic wake_req,
    input  logic lvi_exit,
    input  logic short_rec,
    output logic in_stop,
    output logic stopped,
    output logic cpu_run
);

    localparam int unsigned CNT_W = $clog2(LONG_DLY + 1);
    localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_DLY);
    localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_DLY);

    typedef struct packed {
        stoprec_state_e   state;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        case (tmr_q.state)
            ST_RUN: begin
                if (stop_enter) tmr_d.state = ST_STOP;
            end
            ST_STOP: begin
                if (lvi_exit) begin
                    tmr_d.state = ST_RECOVER;
                    tmr_d.cnt   = LONG_CNT;
                end else if (wake_req) begin
                    tmr_d.state = ST_RECOVER;
                    tmr_d.cnt   = short_rec ? SHORT_CNT : LONG_CNT;
                end
            end
            ST_RECOVER: begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
                if (tmr_q.cnt == CNT_W'(1)) begin
                    tmr_d.state = ST_RUN;
                end
            end
            default: begin
                tmr_d.state = ST_RUN;
                tmr_d.cnt   = '0;
            end
        endcase
        if (rst_any) begin
            tmr_d.state = ST_RUN;
            tmr_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign in_stop = (tmr_q.state != ST_RUN);
    assign stopped = (tmr_q.state == ST_STOP);
    assign cpu_run = (tmr_q.state == ST_RUN);

    // R5
    stop_entry_chk: assert property (@(posedge clk) disable iff (rst_any)
        (tmr_q.state == ST_RUN && stop_enter) |=> !cpu_run);

    // R8
    lvi_long_chk: assert property (@(posedge clk) disable iff (rst_any)
        (tmr_q.state == ST_STOP && lvi_exit) |=> (tmr_q.cnt == LONG_CNT));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (rst_any)
        (tmr_q.state == ST_RECOVER && tmr_q.cnt != CNT_W'(1))
            |=> (tmr_q.state == ST_RECOVER) && (tmr_q.cnt == $past(tmr_q.cnt) - CNT_W'(1)));

    // R6
    finish_chk: assert property (@(posedge clk) disable iff (rst_any)
        (tmr_q.state == ST_RECOVER && tmr_q.cnt == CNT_W'(1)) |=> cpu_run);

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst_any)
        tmr_q.cnt <= LONG_CNT);

endmodule

// File: rtl/stoprec_ctrl.sv
module stoprec_ctrl
    import stoprec_pkg::*;
#(
    parameter int unsigned SHORT_DLY = 32,
    parameter int unsigned LONG_DLY  = 4096
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             stop_enter,
    input  logic             wake_req,
    input  logic             lvi_detect,
    output logic             lvi_enable,
    output logic             lvi_reset,
    output logic             lvi_mode_5v,
    output logic             cpu_run
);

    stoprec_cfg_t cfg;
    logic rst_any;
    logic in_stop;
    logic stopped;
    logic lvi_exit;

    assign rst_any  = !por_n || !rst_n;
    assign lvi_exit = lvi_reset && stopped;

    stoprec_cfg_reg u_cfg (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg)
    );

    stoprec_lvi_ctrl u_lvi (
        .clk         (clk),
        .rst_any     (rst_any),
        .cfg         (cfg),
        .in_stop     (in_stop),
        .lvi_detect  (lvi_detect),
        .lvi_enable  (lvi_enable),
        .lvi_reset   (lvi_reset),
        .lvi_mode_5v (lvi_mode_5v)
    );

    stoprec_wake_timer #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY)
    ) u_tmr (
        .clk        (clk),
        .rst_any    (rst_any),
        .stop_enter (stop_enter),
        .wake_req   (wake_req),
        .lvi_exit   (lvi_exit),
        .short_rec  (cfg.short_rec),
        .in_stop    (in_stop),
        .stopped    (stopped),
        .cpu_run    (cpu_run)
    );

endmodule

// File: tb/test_stoprec_ctrl.sv
`timescale 1ns/1ps
module test_stoprec_ctrl;

    localparam int SHORT_DLY = 32;
    localparam int LONG_DLY  = 4096;

    logic clk = 1'b0;
    logic por_n, rst_n, cfg_wr, stop_enter, wake_req, lvi_detect;
    logic [4:0] cfg_wdata;
    logic lvi_enable, lvi_reset, lvi_mode_5v, cpu_run;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stoprec_ctrl #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) i_stoprec_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .stop_enter(stop_enter), .wake_req(wake_req),
        .lvi_detect(lvi_detect), .lvi_enable(lvi_enable), .lvi_reset(lvi_reset),
        .lvi_mode_5v(lvi_mode_5v), .cpu_run(cpu_run)
    );

    // {cfg[4:0], detect, exp_enable, exp_reset, exp_mode}; checked while running
    localparam logic [8:0] VEC [8] = '{
        {5'b00000, 1'b1, 1'b1, 1'b1, 1'b0},
        {5'b00100, 1'b1, 1'b1, 1'b0, 1'b0},
        {5'b01000, 1'b1, 1'b0, 1'b0, 1'b0},
        {5'b10000, 1'b0, 1'b1, 1'b0, 1'b1},
        {5'b10010, 1'b1, 1'b1, 1'b1, 1'b1},
        {5'b01010, 1'b1, 1'b0, 1'b0, 1'b0},
        {5'b00001, 1'b0, 1'b1, 1'b0, 1'b0},
        {5'b11100, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [4:0] v);
        cfg_wdata = v;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic enter_stop();
        stop_enter = 1'b1;
        @(negedge clk);
        stop_enter = 1'b0;
    endtask

    // Counts falling edges with cpu_run low after the accepting edge.
    // Optionally writes wdata at the 3rd and pulses wake at the 5th low cycle.
    task automatic measure(output int n, input bit do_wr, input logic [4:0] wdata);
        n = 0;
        while (!cpu_run && n < 5000) begin
            if (do_wr && n == 3) begin
                cfg_wdata = wdata;
                cfg_wr = 1'b1;
            end else begin
                cfg_wr = 1'b0;
            end
            wake_req = (n == 5);
            n++;
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        wake_req = 1'b0;
    endtask

    initial begin
        int n;
        por_n = 1'b0; rst_n = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0;
        stop_enter = 1'b0; wake_req = 1'b0; lvi_detect = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R11 reset cpu_run", cpu_run, 1);
        check("R11 reset mode", lvi_mode_5v, 0);
        check("R2 reset enable", lvi_enable, 1);

        // Vector table: R1..R4 while running
        foreach (VEC[i]) begin
            write_cfg(VEC[i][8:4]);
            lvi_detect = VEC[i][3];
            @(negedge clk);
            check("R1/R2 enable vector", lvi_enable, int'(VEC[i][2]));
            check("R3 reset vector", lvi_reset, int'(VEC[i][1]));
            check("R4 mode vector", lvi_mode_5v, int'(VEC[i][0]));
            lvi_detect = 1'b0;
        end

        // R12: wake while running ignored
        write_cfg(5'b00001);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        @(negedge clk);
        check("R12 wake in run", cpu_run, 1);

        // R5 + R6 short recovery, R2 monitor off in stop
        enter_stop();
        check("R5 stop entry", cpu_run, 0);
        check("R2 enable off in stop", lvi_enable, 0);
        lvi_detect = 1'b1;
        @(negedge clk);
        check("R3 no reset when off", lvi_reset, 0);
        lvi_detect = 1'b0;
        repeat (10) @(negedge clk);
        check("R5 stays stopped", cpu_run, 0);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        measure(n, 1'b0, 5'b0);
        check("R6 short delay", n, SHORT_DLY);

        // R9: write short=0 mid-recovery, plus R12 wake mid-recovery
        enter_stop();
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        measure(n, 1'b1, 5'b00000);
        check("R9 write during short recovery", n, SHORT_DLY);

        // R7 long recovery
        enter_stop();
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        measure(n, 1'b0, 5'b0);
        check("R7 long delay", n, LONG_DLY);

        // R8 LVI exit takes long delay despite short bit; R9 write ignored
        write_cfg(5'b00011);
        enter_stop();
        check("R2 enable kept in stop", lvi_enable, 1);
        lvi_detect = 1'b1;
        #1;
        check("R8 lvi_reset in stop", lvi_reset, 1);
        @(negedge clk);
        lvi_detect = 1'b0;
        measure(n, 1'b1, 5'b00011);
        check("R8 lvi exit long delay", n, LONG_DLY);

        // R10 general reset keeps mode, clears others, even from stop
        write_cfg(5'b11000);
        check("R1 pwr_off written", lvi_enable, 0);
        check("R4 mode written", lvi_mode_5v, 1);
        enter_stop();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 mode kept", lvi_mode_5v, 1);
        check("R10 pwr_off cleared", lvi_enable, 1);
        check("R10 cpu_run high", cpu_run, 1);

        // R11 power-on reset clears mode
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R11 mode cleared", lvi_mode_5v, 0);
        check("R11 cpu_run", cpu_run, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule